// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block chooses which hardware thread owns the next retirement slot in a multithreaded out-of-order core. For every thread it sees a 3-bit status code, a flag saying that the thread's reorder buffer is empty, a flag saying that the buffer's head is ready, and the sequence number of that head. It returns a valid flag and the index of the chosen thread. When valid is low, no thread qualifies and commit stops for this cycle.

A static policy input picks between two modes. In the rotating mode, an ordered list of thread indices is scanned from the front. Each time a commit is actually taken, the thread that won moves to the back of the list. In the oldest-first mode, the block compares the head sequence numbers of all qualifying threads and picks the smallest. The selection is purely combinational. The only state is the rotation list, which changes on a clock edge when the advance strobe reports a taken commit. When the block is built for a single thread, it reduces to a status check.

Top module: `smt_commit_pick`

## Requirements
- R1: Status codes 0 (idle), 1 (running) and 4 (fetch trap pending) make a thread eligible. Codes 2 (squashing), 3 (trap pending), 5, 6 and 7 make it ineligible. An ineligible thread is never reported.
- R2: With policy 0 (rotating), the output is the first thread in the priority list that is eligible and has its head-ready bit set.
- R3: With policy 0, a clock edge that sees adv_i high while pick_vld_o is high moves the picked thread to the back of the list. The threads that were behind it each move one place forward.
- R4: The list is left unchanged by an edge where adv_i is low, where pick_vld_o is low, or where the policy is not 0.
- R5: With policy 1 (oldest first), the output is the thread with the smallest unsigned head sequence number among the threads that are eligible, non-empty and head-ready.
- R6: Policy codes 2 and 3 (aggressive) select exactly as policy 1 does.
- R7: When no thread qualifies under the active policy, pick_vld_o is low.
- R8: Reset sets the list to ascending order, thread 0 at the front.
- R9: With NTHR = 1, pick_vld_o equals the eligibility of thread 0's status, and the ready, empty and sequence inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | 0 rotating, 1 oldest first, 2 or 3 aggressive |
| state_i | input | NTHR*3 | Status code per thread, thread t at bits [3t+2:3t] |
| rob_empty_i | input | NTHR | Reorder buffer empty, one bit per thread |
| head_rdy_i | input | NTHR | Buffer head ready to retire, one bit per thread |
| head_seq_i | input | NTHR*SEQW | Head sequence number, thread t at bits [SEQW*t+SEQW-1:SEQW*t] |
| adv_i | input | 1 | A commit was taken on the current pick |
| pick_vld_o | output | 1 | A thread was selected |
| pick_tid_o | output | IW | Index of the selected thread |

## Verification
The hardest situation to reach is a rotation list that has drifted far from its reset order. The list only moves on taken commits in rotating mode, and its contents are visible only through which thread wins a scan. The bench sweeps every combination of eligibility mask and ready mask under each policy code. It raises the advance strobe on alternating patterns, including patterns where nothing is picked or where the policy is not rotating. This walks the list through many permutations, and the bench's own copy of the list predicts every pick. A separate single-thread instance is driven through all eight status codes.

// File: rtl/smt_commit_pick.sv
module smt_commit_pick #(
  parameter int NTHR = 4,
  parameter int SEQW = 16,
  localparam int IW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           policy_i,
  input  logic [NTHR*3-1:0]    state_i,
  input  logic [NTHR-1:0]      rob_empty_i,
  input  logic [NTHR-1:0]      head_rdy_i,
  input  logic [NTHR*SEQW-1:0] head_seq_i,
  input  logic                 adv_i,
  output logic                 pick_vld_o,
  output logic [IW-1:0]        pick_tid_o
);

  logic [NTHR-1:0] elig;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      elig[t] = (state_i[t*3 +: 3] == 3'd0) || (state_i[t*3 +: 3] == 3'd1) ||
                (state_i[t*3 +: 3] == 3'd4);
    end
  end

  generate
    if (NTHR == 1) begin : g_single
      assign pick_vld_o = elig[0];
      assign pick_tid_o = '0;

      p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o == (state_i[2:0] inside {3'd0, 3'd1, 3'd4}));
    end else begin : g_multi
      logic [IW-1:0] order_q [NTHR];
      logic          rr_vld, old_vld;
      logic [IW-1:0] rr_pos, rr_tid, old_tid;
      logic [SEQW-1:0] old_seq;
      logic          rotate;

      always_comb begin
        rr_vld = 1'b0;
        rr_pos = '0;
        for (int k = 0; k < NTHR; k++) begin
          if (!rr_vld && elig[order_q[k]] && head_rdy_i[order_q[k]]) begin
            rr_vld = 1'b1;
            rr_pos = IW'(k);
          end
        end
      end
      assign rr_tid = order_q[rr_pos];

      always_comb begin
        old_vld = 1'b0;
        old_tid = '0;
        old_seq = '0;
        for (int t = 0; t < NTHR; t++) begin
          if (elig[t] && !rob_empty_i[t] && head_rdy_i[t] &&
              (!old_vld || head_seq_i[t*SEQW +: SEQW] < old_seq)) begin
            old_vld = 1'b1;
            old_tid = IW'(t);
            old_seq = head_seq_i[t*SEQW +: SEQW];
          end
        end
      end

      assign pick_vld_o = (policy_i == 2'd0) ? rr_vld : old_vld;
      assign pick_tid_o = (policy_i == 2'd0) ? rr_tid : old_tid;
      assign rotate     = adv_i && rr_vld && (policy_i == 2'd0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < NTHR; k++) order_q[k] <= IW'(k);
        end else if (rotate) begin
          for (int k = 0; k < NTHR - 1; k++) begin
            if (k >= int'(rr_pos)) order_q[k] <= order_q[k+1];
          end
          order_q[NTHR-1] <= rr_tid;
        end
      end

      logic [NTHR*IW-1:0] order_flat;
      logic [NTHR-1:0]    seen;
      always_comb begin
        seen = '0;
        for (int k = 0; k < NTHR; k++) begin
          order_flat[k*IW +: IW] = order_q[k];
          seen[order_q[k]] = 1'b1;
        end
      end

      p_elig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |-> (state_i[pick_tid_o*3 +: 3] inside {3'd0, 3'd1, 3'd4}));
      p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |-> head_rdy_i[pick_tid_o]);
      p_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && pick_vld_o && policy_i == 2'd0) |=> order_q[NTHR-1] == $past(pick_tid_o));
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_i && pick_vld_o && policy_i == 2'd0) |=> $stable(order_flat));
      p_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld_o && policy_i != 2'd0) |-> !rob_empty_i[pick_tid_o]);
      p_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NTHR);
    end
  endgenerate

endmodule

// File: tb/smt_commit_pick_tb.sv
module smt_commit_pick_tb;
  localparam int PER = 10;
  localparam int N = 4;
  localparam int SW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] policy;
  logic [N*3-1:0] state;
  logic [N-1:0] empty, rdy;
  logic [N*SW-1:0] seq;
  logic adv;
  logic vld;
  logic [1:0] tid;

  logic [2:0] st1;
  logic rdy1, emp1;
  logic [SW-1:0] seq1;
  logic vld1;
  logic tid1;

  int checks = 0, fails = 0;
  int ord [N];

  always #(PER/2) clk = ~clk;

  smt_commit_pick #(.NTHR(N), .SEQW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy_i(policy), .state_i(state),
    .rob_empty_i(empty), .head_rdy_i(rdy), .head_seq_i(seq), .adv_i(adv),
    .pick_vld_o(vld), .pick_tid_o(tid));

  smt_commit_pick #(.NTHR(1), .SEQW(SW)) u_one (
    .clk(clk), .rst_n(rst_n), .policy_i(2'd0), .state_i(st1),
    .rob_empty_i(emp1), .head_rdy_i(rdy1), .head_seq_i(seq1), .adv_i(1'b0),
    .pick_vld_o(vld1), .pick_tid_o(tid1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(PER * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    policy = 0; state = '0; empty = '0; rdy = '1; adv = 0; seq = '0;
    st1 = 0; rdy1 = 0; emp1 = 1; seq1 = 0;
    for (int k = 0; k < N; k++) ord[k] = k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R8: reset order puts thread 0 at the front
    chk("R8 vld", vld, 1);
    chk("R8 tid", tid, 0);
    rdy = 4'b1110; #1;
    chk("R8 second", tid, 1);

    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 16; e++) begin
        for (int r = 0; r < 16; r++) begin
          int it, ev, et, bs, a;
          int ec [3];
          int ic [3];
          ec = '{0, 1, 4};
          ic = '{2, 3, 5};
          it = p * 256 + e * 16 + r;
          @(negedge clk);
          policy = 2'(p);
          rdy = 4'(r);
          empty = 4'((r * 3 + e) >> 1);
          for (int t = 0; t < N; t++) begin
            state[t*3 +: 3] = e[t] ? 3'(ec[(t + e) % 3]) : 3'(ic[(t + r) % 3]);
            seq[t*SW +: SW] = 16'(((t + it) % 4) * 4096 + (it % 4096));
          end
          a = (e + r + p) % 2;
          adv = a[0];
          ev = 0; et = 0; bs = 0;
          if (p == 0) begin
            for (int k = 0; k < N; k++)
              if (!ev && e[ord[k]] && r[ord[k]]) begin ev = 1; et = ord[k]; end
          end else begin
            for (int t = 0; t < N; t++)
              if (e[t] && !empty[t] && r[t] && (!ev || int'(seq[t*SW +: SW]) < bs)) begin
                ev = 1; et = t; bs = int'(seq[t*SW +: SW]);
              end
          end
          #1;
          if (p == 0) begin
            chk("R2/R7 vld", vld, ev);
            if (ev) chk("R2/R4 tid", tid, et);
          end else if (p == 1) begin
            chk("R5/R7 vld", vld, ev);
            if (ev) chk("R5 tid", tid, et);
          end else begin
            chk("R6 vld", vld, ev);
            if (ev) chk("R6 tid", tid, et);
          end
          if (vld) chk("R1 picked eligible", e[tid], 1);
          // R3 model: rotate on taken commit in rotating mode
          if (p == 0 && ev && a == 1) begin
            int pos;
            pos = 0;
            for (int k = 0; k < N; k++) if (ord[k] == et) pos = k;
            for (int k = pos; k < N - 1; k++) ord[k] = ord[k+1];
            ord[N-1] = et;
          end
        end
      end
    end

    @(negedge clk);
    adv = 0; policy = 0; rdy = '1;
    for (int t = 0; t < N; t++) state[t*3 +: 3] = 3'd1;
    #1;
    chk("R3 front after sweep", tid, ord[0]);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      st1 = 3'(c); rdy1 = c[0]; emp1 = c[1]; seq1 = 16'(c * 77);
      #1;
      chk("R9 vld", vld1, (c == 0 || c == 1 || c == 4) ? 1 : 0);
      chk("R9 tid", tid1, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule